// File: doc/BRIEF.md
# Serial Transmit Completion and Underrun Monitor

This block is a byte-wide serial transmitter that takes entries from a show-ahead transmit FIFO and shifts them out on a single data line. Each shift happens on a bit-rate enable strobe. It supports three line modes. Bit-synchronous framed mode wraps each frame in flag characters. Character-synchronous mode sends raw characters. Asynchronous mode adds a start bit and a stop bit to each character. While it transmits, the block watches for two conditions: a transmission that has fully drained, and a FIFO that ran dry before the data was complete.

When the FIFO runs dry in framed mode, the frame is closed with a run of ones that aborts it. In character-synchronous mode the line simply falls back to ones. In both cases the transmitter then freezes. It does not touch the FIFO again until software issues a transmitter reset. Both conditions are latched as sticky status bits, which drive an interrupt request and a small vector code. Each bit is cleared only by acknowledging its vector. The underrun condition cannot be masked, so it always reaches software through a vector.

Top module: `sertx_monitor`

## Requirements
- R1: After `rst`, the outputs are: `txd` = 1, `fifo_pop` = 0, both status bits 0, `irq_req` = 0 and `irq_vec` = 2'b00.
- R2: With `mode` = 2'b00 (framed), a frame starts with the flag 0x7E. The data bytes follow, and after the byte whose `fifo_last` tag is 1 a closing 0x7E is sent. Every character goes out LSB first, one bit per `tx_en` strobe. With no symbol loaded, `txd` is 1.
- R3: In framed mode, `stat_allsent` is set on the `tx_en` strobe that ends the last bit period of the closing flag.
- R4: In framed mode, a FIFO that is empty at a character boundary, with no tagged byte sent yet, causes an abort. The abort is `ABORT_ONES` ones (at least 7). `stat_underrun` is set on that boundary strobe, and the transmitter halts.
- R5: With `mode` = 2'b01 (character-synchronous), bytes are sent raw, LSB first. `stat_allsent` is set at the end of a tagged byte only if the FIFO is empty at that moment. Otherwise transmission goes on with the next byte.
- R6: In character-synchronous mode, an empty FIFO at a boundary after an untagged byte sets `stat_underrun`. The line then idles at 1 and the transmitter halts.
- R7: With `mode[1]` = 1 (asynchronous), each byte is sent as a 0 start bit, the data LSB first and a 1 stop bit. `stat_allsent` is set when a character ends with the FIFO empty. The tag has no effect, and an underrun never occurs in this mode.
- R8: While halted, the block asserts no `fifo_pop` and holds `txd` at 1, whatever the FIFO holds, until `xmit_reset` is pulsed.
- R9: `xmit_reset` flushes the shifter, sets `txd` to 1 and lets FIFO reads start again. It leaves `stat_underrun` unchanged.
- R10: Status bits are sticky. An `irq_ack` clears the bit named by the current `irq_vec`. A new event for that same bit in the same cycle keeps it set.
- R11: `irq_vec` is 2'b10 while underrun is pending. Otherwise it is 2'b01 while all-sent is pending and unmasked, and 2'b00 when neither holds. `irq_req` equals (`irq_vec` != 0). `irq_mask[0]` masks all-sent. `irq_mask[1]` has no effect.
- R12: `fifo_pop` pulses for one cycle, in the cycle after the strobe that consumed the FIFO head. There is exactly one pulse per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Bit-rate enable strobe |
| mode | input | 2 | 00 framed, 01 character-synchronous, 1x asynchronous |
| fifo_data | input | DATA_W | Head entry of the transmit FIFO |
| fifo_last | input | 1 | Frame-end tag of the head entry |
| fifo_empty | input | 1 | FIFO holds no entry |
| xmit_reset | input | 1 | Transmitter reset command pulse |
| irq_mask | input | 2 | Bit 0 masks all-sent; bit 1 is ignored |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| txd | output | 1 | Serial data line |
| fifo_pop | output | 1 | Consume the FIFO head |
| stat_allsent | output | 1 | Sticky all-sent status |
| stat_underrun | output | 1 | Sticky underrun status |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Vector code of the highest-priority pending event |

## Verification
The bench builds the block with `DATA_W` = 8 and `ABORT_ONES` = 7, the shortest abort the line permits. This lets the bench check that the abort bits and the idle ones after the halt form one unbroken run of ones, and that `stat_underrun` rises exactly on the boundary strobe. With the strobe asserted every cycle, the character boundaries in the three modes fall on fixed cycles, at steps of 8 or 10 strobes. This places the all-sent edge, the acknowledge collision and the one-bit gap between back-to-back framed frames at cycles the bench can compute.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    LINE_FRAMED   = 2'b00,
    LINE_CHARSYNC = 2'b01,
    LINE_ASYNC    = 2'b10,
    LINE_ASYNC_B  = 2'b11
  } line_mode_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_OPEN,
    SQ_DATA,
    SQ_CLOSE,
    SQ_ABORT,
    SQ_HALT
  } seq_state_t;

  localparam logic [7:0] FRAME_FLAG = 8'h7E;

  localparam logic [1:0] VEC_NONE  = 2'b00;
  localparam logic [1:0] VEC_DONE  = 2'b01;
  localparam logic [1:0] VEC_UNDER = 2'b10;

  // Per-source maskability: bit 0 all-sent, bit 1 underrun (never maskable)
  localparam logic [1:0] MASKABLE = 2'b01;

endpackage

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int SYM_W = 10,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             tx_en,
  input  logic             load,
  input  logic [SYM_W-1:0] sym,
  input  logic [LEN_W-1:0] len,
  output logic             txd,
  output logic             busy
);

  logic [SYM_W-1:0] sh_q;
  logic [LEN_W-1:0] cnt_q;
  logic             txd_q;

  // First bit goes out on the load strobe; remaining len-1 bits follow
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh_q  <= '0;
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else if (tx_en) begin
      if (load) begin
        txd_q <= sym[0];
        sh_q  <= sym >> 1;
        cnt_q <= len - 1'b1;
      end else if (cnt_q != '0) begin
        txd_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        txd_q <= 1'b1;
      end
    end
  end

  assign txd  = txd_q;
  assign busy = (cnt_q != '0);

  // R2
  idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !load && !flush && cnt_q == '0) |=> txd_q);

  // R2
  load_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && load && !flush) |=> (txd_q == $past(sym[0])));

endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYM_W      = 10,
  parameter int LEN_W      = 4,
  parameter int ABORT_ONES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xmit_reset,
  input  logic              tx_en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  input  logic              fifo_empty,
  input  logic              sh_busy,
  output logic              load,
  output logic [SYM_W-1:0]  sym,
  output logic [LEN_W-1:0]  len,
  output logic              fifo_pop,
  output logic              ev_done,
  output logic              ev_under
);

  localparam logic [SYM_W-1:0] FLAG_SYM  = ({SYM_W{1'b1}} << 8) | SYM_W'(FRAME_FLAG);
  localparam logic [SYM_W-1:0] ONES_SYM  = {SYM_W{1'b1}};
  localparam logic [LEN_W-1:0] FLAG_LEN  = LEN_W'(8);
  localparam logic [LEN_W-1:0] ABORT_LEN = LEN_W'(ABORT_ONES);
  localparam logic [LEN_W-1:0] RAW_LEN   = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] ASY_LEN   = LEN_W'(DATA_W + 2);

  seq_state_t st_q, st_n;
  logic       last_q, last_n;
  logic       pop_q;
  logic       take;
  logic       boundary;
  logic       is_framed, is_async;
  logic [SYM_W-1:0] data_sym;
  logic [LEN_W-1:0] data_len;

  assign is_framed = (mode == LINE_FRAMED);
  assign is_async  = mode[1];
  assign boundary  = tx_en && !sh_busy && !xmit_reset;

  // Character framing per mode
  always_comb begin
    if (is_async) begin
      data_sym = {1'b1, fifo_data, 1'b0};
      data_len = ASY_LEN;
    end else begin
      data_sym = {2'b11, fifo_data};
      data_len = RAW_LEN;
    end
  end

  always_comb begin
    st_n     = st_q;
    last_n   = last_q;
    load     = 1'b0;
    sym      = ONES_SYM;
    len      = '0;
    take     = 1'b0;
    ev_done  = 1'b0;
    ev_under = 1'b0;
    if (boundary) begin
      case (st_q)
        SQ_IDLE: begin
          if (!fifo_empty) begin
            if (is_framed) begin
              load = 1'b1;
              sym  = FLAG_SYM;
              len  = FLAG_LEN;
              st_n = SQ_OPEN;
            end else begin
              take = 1'b1;
              st_n = SQ_DATA;
            end
          end
        end
        SQ_OPEN: begin
          if (!fifo_empty) begin
            take = 1'b1;
            st_n = SQ_DATA;
          end else begin
            load     = 1'b1;
            len      = ABORT_LEN;
            ev_under = 1'b1;
            st_n     = SQ_ABORT;
          end
        end
        SQ_DATA: begin
          if (is_framed) begin
            if (last_q) begin
              load = 1'b1;
              sym  = FLAG_SYM;
              len  = FLAG_LEN;
              st_n = SQ_CLOSE;
            end else if (!fifo_empty) begin
              take = 1'b1;
            end else begin
              load     = 1'b1;
              len      = ABORT_LEN;
              ev_under = 1'b1;
              st_n     = SQ_ABORT;
            end
          end else if (!fifo_empty) begin
            take = 1'b1;
          end else if (is_async || last_q) begin
            ev_done = 1'b1;
            st_n    = SQ_IDLE;
          end else begin
            ev_under = 1'b1;
            st_n     = SQ_HALT;
          end
        end
        SQ_CLOSE: begin
          ev_done = 1'b1;
          st_n    = SQ_IDLE;
        end
        SQ_ABORT: st_n = SQ_HALT;
        SQ_HALT:  st_n = SQ_HALT;
        default:  st_n = SQ_IDLE;
      endcase
      if (take) begin
        load   = 1'b1;
        sym    = data_sym;
        len    = data_len;
        last_n = fifo_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || xmit_reset) begin
      st_q   <= SQ_IDLE;
      last_q <= 1'b0;
      pop_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      last_q <= last_n;
      pop_q  <= take;
    end
  end

  assign fifo_pop = pop_q;

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HALT && !xmit_reset) |=> (st_q == SQ_HALT));

  // R8
  halt_nopop_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HALT) |=> !pop_q);

  // R12
  pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pop_q |=> !pop_q);

  // R7
  async_no_under_chk: assert property (@(posedge clk) disable iff (rst)
    is_async |-> !ev_under);

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_done,
  input  logic       ev_under,
  input  logic [1:0] irq_mask,
  input  logic       irq_ack,
  output logic       stat_done,
  output logic       stat_under,
  output logic       irq_req,
  output logic [1:0] irq_vec
);

  logic       done_q, under_q, req_q;
  logic [1:0] vec_q;
  logic       done_n, under_n;
  logic [1:0] vec_n;
  logic [1:0] mask_eff;
  logic       clr_done, clr_under;

  assign mask_eff  = irq_mask & MASKABLE;
  assign clr_done  = irq_ack && (vec_q == VEC_DONE);
  assign clr_under = irq_ack && (vec_q == VEC_UNDER);

  // A fresh event wins over a clear in the same cycle
  always_comb begin
    done_n  = ev_done  | (done_q  & ~clr_done);
    under_n = ev_under | (under_q & ~clr_under);
    if (under_n && !mask_eff[1])
      vec_n = VEC_UNDER;
    else if (done_n && !mask_eff[0])
      vec_n = VEC_DONE;
    else
      vec_n = VEC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      under_q <= 1'b0;
      req_q   <= 1'b0;
      vec_q   <= VEC_NONE;
    end else begin
      done_q  <= done_n;
      under_q <= under_n;
      req_q   <= (vec_n != VEC_NONE);
      vec_q   <= vec_n;
    end
  end

  assign stat_done  = done_q;
  assign stat_under = under_q;
  assign irq_req    = req_q;
  assign irq_vec    = vec_q;

  // R11
  under_irq_chk: assert property (@(posedge clk) disable iff (rst)
    under_q |-> (req_q && vec_q == VEC_UNDER));

  // R10
  under_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (under_q && !irq_ack) |=> under_q);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !irq_ack) |=> done_q);

  // R11
  vec_code_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_q));

endmodule

// File: rtl/sertx_monitor.sv
module sertx_monitor
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ABORT_ONES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  input  logic              fifo_empty,
  input  logic              xmit_reset,
  input  logic [1:0]        irq_mask,
  input  logic              irq_ack,
  output logic              txd,
  output logic              fifo_pop,
  output logic              stat_allsent,
  output logic              stat_underrun,
  output logic              irq_req,
  output logic [1:0]        irq_vec
);

  localparam int SYM_W = DATA_W + 2;
  localparam int LEN_W = $clog2(SYM_W + 1);

  logic             sh_load, sh_busy;
  logic [SYM_W-1:0] sh_sym;
  logic [LEN_W-1:0] sh_len;
  logic             ev_done, ev_under;

  sertx_sequencer #(
    .DATA_W(DATA_W), .SYM_W(SYM_W), .LEN_W(LEN_W), .ABORT_ONES(ABORT_ONES)
  ) u_seq (
    .clk(clk), .rst(rst), .xmit_reset(xmit_reset), .tx_en(tx_en),
    .mode(mode), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_empty(fifo_empty), .sh_busy(sh_busy),
    .load(sh_load), .sym(sh_sym), .len(sh_len), .fifo_pop(fifo_pop),
    .ev_done(ev_done), .ev_under(ev_under)
  );

  sertx_shifter #(.SYM_W(SYM_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .flush(xmit_reset), .tx_en(tx_en),
    .load(sh_load), .sym(sh_sym), .len(sh_len), .txd(txd), .busy(sh_busy)
  );

  sertx_irq u_irq (
    .clk(clk), .rst(rst), .ev_done(ev_done), .ev_under(ev_under),
    .irq_mask(irq_mask), .irq_ack(irq_ack),
    .stat_done(stat_allsent), .stat_under(stat_underrun),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // R9
  reset_keeps_under_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_underrun && xmit_reset && !irq_ack) |=> stat_underrun);

endmodule

// File: tb/test_sertx_monitor.sv
module test_sertx_monitor;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] fifo_data;
  logic       fifo_last;
  logic       fifo_empty;
  logic       xmit_reset = 1'b0;
  logic [1:0] irq_mask = 2'b00;
  logic       irq_ack = 1'b0;
  logic       txd, fifo_pop, stat_allsent, stat_underrun, irq_req;
  logic [1:0] irq_vec;

  logic [8:0] fmem [0:15];
  int wr = 0;
  int rd = 0;

  logic cap_txd [0:63];
  logic cap_as  [0:63];
  logic cap_ur  [0:63];
  logic exp_bits [0:63];
  int   exp_n;
  int   pops;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_empty = (wr == rd);
  assign fifo_data  = fmem[rd[3:0]][7:0];
  assign fifo_last  = fmem[rd[3:0]][8];

  always @(posedge clk) begin
    if (rst) rd <= 0;
    else if (fifo_pop) rd <= rd + 1;
  end

  sertx_monitor #(.DATA_W(8), .ABORT_ONES(7)) i_sertx_monitor (
    .clk(clk), .rst(rst), .tx_en(tx_en), .mode(mode),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_empty(fifo_empty),
    .xmit_reset(xmit_reset), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .txd(txd), .fifo_pop(fifo_pop), .stat_allsent(stat_allsent),
    .stat_underrun(stat_underrun), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic tag);
    fmem[wr[3:0]] = {tag, d};
    wr++;
  endtask

  task automatic exp_clear();
    exp_n = 0;
  endtask

  task automatic exp_sym(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_bits[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic exp_fill(input int upto);
    while (exp_n < upto) begin
      exp_bits[exp_n] = 1'b1;
      exp_n++;
    end
  endtask

  task automatic check_stream(input string tag, input int n);
    int bad;
    bad = -1;
    for (int i = 0; i < n; i++)
      if (cap_txd[i] !== exp_bits[i] && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s bit %0d actual=%0b expected=%0b", tag, bad, cap_txd[bad], exp_bits[bad]);
    end
  endtask

  // Strobe n times; sample k is taken just after strobe edge k
  task automatic run(input int n, input int ack_at);
    pops = 0;
    tx_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k == ack_at) irq_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_ack = 1'b0;
      cap_txd[k] = txd;
      cap_as[k]  = stat_allsent;
      cap_ur[k]  = stat_underrun;
      if (fifo_pop) pops++;
    end
    tx_en = 1'b0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic xres_pulse();
    xmit_reset = 1'b1;
    @(negedge clk);
    xmit_reset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 txd", int'(txd), 1);
    chk("R1 fifo_pop", int'(fifo_pop), 0);
    chk("R1 allsent", int'(stat_allsent), 0);
    chk("R1 underrun", int'(stat_underrun), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 irq_vec", int'(irq_vec), 0);
  endtask

  task automatic t_framed();
    mode = 2'b00; irq_mask = 2'b00;
    push(8'hA5, 1'b0); push(8'h3C, 1'b1);
    run(44, -1);
    exp_clear(); exp_sym(16'h7E, 8); exp_sym(16'hA5, 8); exp_sym(16'h3C, 8); exp_sym(16'h7E, 8); exp_fill(44);
    check_stream("R2 framed stream", 44);
    chk("R3 allsent before close end", int'(cap_as[31]), 0);
    chk("R3 allsent at close end", int'(cap_as[32]), 1);
    chk("R11 vec all-sent", int'(irq_vec), 1);
    chk("R11 irq_req", int'(irq_req), 1);
    chk("R12 pops per byte", pops, 2);
    ack_pulse();
    chk("R10 ack clears all-sent", int'(stat_allsent), 0);
    chk("R11 req drops", int'(irq_req), 0);
  endtask

  task automatic t_mask_and_collision();
    irq_mask = 2'b01;
    push(8'h81, 1'b1);
    run(36, -1);
    chk("R3 short frame allsent", int'(cap_as[24]), 1);
    chk("R11 masked all-sent no req", int'(irq_req), 0);
    chk("R11 masked vec", int'(irq_vec), 0);
    irq_mask = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R11 unmasked vec", int'(irq_vec), 1);
    push(8'h55, 1'b1);
    run(30, 24);
    chk("R10 event wins over ack", int'(stat_allsent), 1);
    ack_pulse();
    chk("R10 plain ack clears", int'(stat_allsent), 0);
  endtask

  task automatic t_framed_underrun();
    irq_mask = 2'b11;
    push(8'hC3, 1'b0);
    run(40, -1);
    exp_clear(); exp_sym(16'h7E, 8); exp_sym(16'hC3, 8); exp_fill(40);
    check_stream("R4 abort ones", 40);
    chk("R4 underrun before boundary", int'(cap_ur[15]), 0);
    chk("R4 underrun at boundary", int'(cap_ur[16]), 1);
    chk("R11 underrun vec despite mask", int'(irq_vec), 2);
    chk("R11 underrun req despite mask", int'(irq_req), 1);
    push(8'h0F, 1'b1);
    run(30, -1);
    exp_clear(); exp_fill(30);
    check_stream("R8 halted line ones", 30);
    chk("R8 halted no pop", pops, 0);
    xres_pulse();
    chk("R9 underrun kept by reset", int'(stat_underrun), 1);
    chk("R9 txd idle after reset", int'(txd), 1);
    irq_mask = 2'b00;
    run(40, -1);
    exp_clear(); exp_sym(16'h7E, 8); exp_sym(16'h0F, 8); exp_sym(16'h7E, 8); exp_fill(40);
    check_stream("R9 resumes after reset", 40);
    chk("R9 pops after reset", pops, 1);
    chk("R11 underrun outranks all-sent", int'(irq_vec), 2);
    ack_pulse();
    chk("R10 ack clears underrun", int'(stat_underrun), 0);
    chk("R11 vec falls to all-sent", int'(irq_vec), 1);
    ack_pulse();
    chk("R10 ack clears all-sent", int'(stat_allsent), 0);
  endtask

  task automatic t_charsync();
    mode = 2'b01;
    push(8'h5A, 1'b1); push(8'h96, 1'b1);
    run(24, -1);
    exp_clear(); exp_sym(16'h5A, 8); exp_sym(16'h96, 8); exp_fill(24);
    check_stream("R5 raw stream", 24);
    chk("R5 tagged with data left no allsent", int'(cap_as[8]), 0);
    chk("R5 allsent when drained", int'(cap_as[16]), 1);
    ack_pulse();
    push(8'hE1, 1'b0);
    run(20, -1);
    exp_clear(); exp_sym(16'hE1, 8); exp_fill(20);
    check_stream("R6 idle ones", 20);
    chk("R6 underrun before boundary", int'(cap_ur[7]), 0);
    chk("R6 underrun at boundary", int'(cap_ur[8]), 1);
    push(8'h12, 1'b1);
    run(16, -1);
    chk("R8 charsync halt no pop", pops, 0);
    ack_pulse();
    chk("R10 underrun cleared", int'(stat_underrun), 0);
    xres_pulse();
  endtask

  task automatic t_async();
    mode = 2'b10;
    push(8'h3B, 1'b0);
    run(30, -1);
    exp_clear();
    exp_sym(16'h0, 1); exp_sym(16'h12, 8); exp_sym(16'h1, 1);
    exp_sym(16'h0, 1); exp_sym(16'h3B, 8); exp_sym(16'h1, 1);
    exp_fill(30);
    check_stream("R7 async framing", 30);
    chk("R7 allsent before end", int'(cap_as[19]), 0);
    chk("R7 allsent at end", int'(cap_as[20]), 1);
    chk("R7 no underrun", int'(stat_underrun), 0);
    chk("R12 async pops", pops, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_framed();
    t_mask_and_collision();
    t_framed_underrun();
    t_charsync();
    t_async();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule